// File: doc/BRIEF.md
# Latched Fault Interrupt and Crowbar Controller

This block is the digital fault-response stage of a multi-rail power supervisor. Every supply channel flags five fault conditions: undervoltage, overvoltage, two auxiliary undervoltage thresholds and an overcurrent or circuit-breaker trip. A tracking-error flag and an external shutdown request pin are also inputs. The block masks these flags with static enable inputs and latches the result into two active-low interrupts. It derives a force-shutdown request from them and drives an active-high crowbar output. It also holds a fault latch that keeps the supervisor from powering up again.

The general interrupt stays inactive while the supervisor is still in reset. After reset is released it stays inactive for a further hold-off time, which is counted in millisecond ticks. The crowbar output can run in one of two modes. In pulse mode it gives a fixed-width pulse to fire an external thyristor. In level mode it gives a steady level that discharges early rails before tracking begins. Overcurrent faults reach the crowbar through their own enables, so milder faults can raise an interrupt without firing the crowbar.

Top module: `fault_resp_ctrl`

## Requirements
- R1: `irq_n` goes low one clock after any fault flag whose matching enable bit is 1. The flag kinds are `uv`, `ov`, `uv1`, `uv2` and `oc`, with `oc` enabled by `en_oc_irq`. A fault flag whose enable bit is 0 never drives `irq_n` low.
- R2: Once low, `irq_n` stays low after the fault flags go away. It returns high only on a high-to-low edge of `irq_clr_n`, which passes through a two-stage synchronizer. If an enabled fault is still present in the cycle of that edge, `irq_n` stays low.
- R3: `irq_n` is held high while `rst_done` is 0. After `rst_done` rises, `irq_n` stays high for a further number of `ms_tick` pulses set by `holdoff_sel`: code 0 gives 0, code 1 gives 200, code 2 gives 400, code 3 gives 800, and codes 4 to 7 give 1600.
- R4: `trk_irq_n` goes low, and stays low until a clear edge, only when `trk_err` and `en_trk` are both 1. No other input drives it low.
- R5: `fsd_req` is 1 while `irq_n` is low and `irq_fsd_en` is 1, or while `trk_irq_n` is low and `trk_fsd_en` is 1.
- R6: The crowbar trigger is the OR of four terms: `oc` masked by `en_oc_cb` (independent of `en_oc_irq`), the general interrupt with `irq_cb_en`, the tracker interrupt with `trk_cb_en`, and `fsd_in` with `fsd_in_cb_en`.
- R7: When `cb_level_mode` is 0, a rising crowbar trigger drives `crowbar` high for exactly PULSE_CYC clocks, starting one clock after the rise. A trigger edge that arrives while a pulse is running neither restarts nor extends the pulse.
- R8: When `cb_level_mode` is 1, `crowbar` equals the crowbar trigger in the same cycle.
- R9: With `latch_en` at 1, a low `irq_n`, a high `fsd_req` or a high `crowbar` sets `pwr_block`. `pwr_block` stays set until a clear edge arrives in a cycle with no enabled live fault. With `latch_en` at 0, `pwr_block` is never set.
- R10: After reset, `irq_n` and `trk_irq_n` are 1, and `fsd_req`, `crowbar` and `pwr_block` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| rst_done | input | 1 | Supervisor reset period has ended |
| uv | input | N_CH | Per-channel undervoltage flags |
| ov | input | N_CH | Per-channel overvoltage flags |
| uv1 | input | N_CH | Per-channel first auxiliary undervoltage flags |
| uv2 | input | N_CH | Per-channel second auxiliary undervoltage flags |
| oc | input | N_CH | Per-channel overcurrent / breaker flags |
| trk_err | input | 1 | Tracking-error flag |
| fsd_in | input | 1 | External shutdown request pin |
| irq_clr_n | input | 1 | Asynchronous active-low interrupt clear |
| en_uv | input | N_CH | Interrupt enables for uv |
| en_ov | input | N_CH | Interrupt enables for ov |
| en_uv1 | input | N_CH | Interrupt enables for uv1 |
| en_uv2 | input | N_CH | Interrupt enables for uv2 |
| en_oc_irq | input | N_CH | Interrupt enables for oc |
| en_oc_cb | input | N_CH | Crowbar enables for oc |
| en_trk | input | 1 | Tracker interrupt enable |
| irq_fsd_en | input | 1 | General interrupt requests shutdown |
| irq_cb_en | input | 1 | General interrupt triggers crowbar |
| trk_fsd_en | input | 1 | Tracker interrupt requests shutdown |
| trk_cb_en | input | 1 | Tracker interrupt triggers crowbar |
| fsd_in_cb_en | input | 1 | Shutdown pin triggers crowbar |
| latch_en | input | 1 | Power-up blocking latch enable |
| cb_level_mode | input | 1 | 1 = level crowbar, 0 = pulse crowbar |
| holdoff_sel | input | 3 | Post-reset interrupt hold-off code |
| irq_n | output | 1 | Latched general interrupt, active low |
| trk_irq_n | output | 1 | Latched tracker interrupt, active low |
| fsd_req | output | 1 | Force-shutdown request |
| crowbar | output | 1 | Crowbar drive, active high |
| pwr_block | output | 1 | Power-up blocked by fault latch |

## Verification
The bench first checks that a clear edge does not release the general interrupt while an enabled fault is still present. A design that gave the clear priority would let the interrupt flicker high for one cycle. It also checks that an overcurrent flag can fire the crowbar without raising the interrupt, and the reverse. A design that shared one mask between the two paths would fail in one direction or the other. The hold-off is checked just short of and just past the 200-tick and saturated 1600-tick limits, which catches off-by-one errors and a missing saturation for the upper codes. In pulse mode the bench counts crowbar-high cycles while it re-fires the trigger in the middle of a pulse. A counter that reloads on the new edge would report a pulse longer than PULSE_CYC.

// File: rtl/fr_pkg.sv
// Package: shared constants and the hold-off code decoder.
// Assumes the hold-off step doubles per code from code 1 upward.
package fr_pkg;
    localparam int unsigned HOLD_STEP_MS = 200;
    localparam int unsigned HOLD_MAX_CODE = 4;

    // Return the hold-off length in ticks for a 3-bit code; codes above 4 saturate.
    function automatic int unsigned holdoff_ticks(input logic [2:0] code);
        int unsigned c;
        c = (code > 3'(HOLD_MAX_CODE)) ? HOLD_MAX_CODE : int'(code);
        if (c == 0) return 0;
        return HOLD_STEP_MS << (c - 1);
    endfunction
endpackage

// File: rtl/fr_clr_sync.sv
// Clear synchronizer: brings the asynchronous active-low clear into the
// clock domain through STAGES flops and flags its assertion edge for one cycle.
// Assumes the clear is held low for at least STAGES+1 clocks.
module fr_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_async,
    output logic clr_evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw clear through the synchronizer chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], clr_n_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    // A high-to-low transition at the chain output is one clear event.
    assign clr_evt = last_q && !sync_q[STAGES-1];
endmodule

// File: rtl/fr_holdoff.sv
// Hold-off timer: after rst_done rises, counts ms ticks up to the length
// chosen by the code and then reports the general interrupt as armed.
// Assumes the code is static while rst_done is high.
module fr_holdoff
    import fr_pkg::*;
#(
    parameter int unsigned MAX_TICKS = HOLD_STEP_MS << (HOLD_MAX_CODE - 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       rst_done,
    input  logic [2:0] sel,
    output logic       armed
);
    localparam int CW = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;

    assign target = CW'(holdoff_ticks(sel));

    // Count ticks while reset is released and the target is not reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_done) begin
            cnt_q <= '0;
        end else if (ms_tick && (cnt_q < target)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign armed = rst_done && (cnt_q >= target);
endmodule

// File: rtl/fr_crowbar.sv
// Crowbar driver: in pulse mode a rising trigger starts a PULSE_CYC-clock
// pulse that is not restarted by later edges; in level mode the output
// follows the trigger directly.
module fr_crowbar #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic level_mode,
    output logic cb_out
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic          trig_q;
    logic [PW-1:0] left_q;

    // Remember the trigger and run the pulse countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            left_q <= '0;
        end else begin
            trig_q <= trig;
            if (level_mode) begin
                left_q <= '0;
            end else if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end else if (trig && !trig_q) begin
                left_q <= PW'(PULSE_CYC);
            end
        end
    end

    assign cb_out = level_mode ? trig : (left_q != '0);
endmodule

// File: rtl/fault_resp_ctrl.sv
// Top: masks per-channel fault flags into a latched general interrupt and a
// latched tracker interrupt, derives the shutdown request and crowbar trigger,
// and holds the power-up blocking latch. Enables are static inputs.
module fault_resp_ctrl
    import fr_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int PULSE_CYC  = 8,
    parameter int SYNC_STAGE = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic            rst_done,
    input  logic [N_CH-1:0] uv,
    input  logic [N_CH-1:0] ov,
    input  logic [N_CH-1:0] uv1,
    input  logic [N_CH-1:0] uv2,
    input  logic [N_CH-1:0] oc,
    input  logic            trk_err,
    input  logic            fsd_in,
    input  logic            irq_clr_n,
    input  logic [N_CH-1:0] en_uv,
    input  logic [N_CH-1:0] en_ov,
    input  logic [N_CH-1:0] en_uv1,
    input  logic [N_CH-1:0] en_uv2,
    input  logic [N_CH-1:0] en_oc_irq,
    input  logic [N_CH-1:0] en_oc_cb,
    input  logic            en_trk,
    input  logic            irq_fsd_en,
    input  logic            irq_cb_en,
    input  logic            trk_fsd_en,
    input  logic            trk_cb_en,
    input  logic            fsd_in_cb_en,
    input  logic            latch_en,
    input  logic            cb_level_mode,
    input  logic [2:0]      holdoff_sel,
    output logic            irq_n,
    output logic            trk_irq_n,
    output logic            fsd_req,
    output logic            crowbar,
    output logic            pwr_block
);
    logic [N_CH-1:0] ch_fault;
    logic            gen_live, trk_live, cb_live, cb_trig;
    logic            clr_evt, armed;
    logic            irq_q, trk_q, blk_q;

    // Per-channel masking of the five fault kinds.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign ch_fault[c] = (uv[c] & en_uv[c]) | (ov[c] & en_ov[c]) |
                             (uv1[c] & en_uv1[c]) | (uv2[c] & en_uv2[c]) |
                             (oc[c] & en_oc_irq[c]);
    end

    assign gen_live = |ch_fault;
    assign trk_live = trk_err & en_trk;
    assign cb_live  = (|(oc & en_oc_cb)) | (fsd_in & fsd_in_cb_en);
    assign cb_trig  = cb_live | (irq_q & irq_cb_en) | (trk_q & trk_cb_en);

    fr_clr_sync #(.STAGES(SYNC_STAGE)) i_clr (
        .clk(clk), .rst_n(rst_n), .clr_n_async(irq_clr_n), .clr_evt(clr_evt)
    );

    fr_holdoff i_hold (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rst_done(rst_done),
        .sel(holdoff_sel), .armed(armed)
    );

    fr_crowbar #(.PULSE_CYC(PULSE_CYC)) i_cb (
        .clk(clk), .rst_n(rst_n), .trig(cb_trig), .level_mode(cb_level_mode),
        .cb_out(crowbar)
    );

    // General interrupt latch: held off until armed, live fault beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) irq_q <= 1'b0;
        else if (gen_live)    irq_q <= 1'b1;
        else if (clr_evt)     irq_q <= 1'b0;
    end

    // Tracker interrupt latch: only the enabled tracking error sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        trk_q <= 1'b0;
        else if (trk_live) trk_q <= 1'b1;
        else if (clr_evt)  trk_q <= 1'b0;
    end

    assign fsd_req = (irq_q & irq_fsd_en) | (trk_q & trk_fsd_en);

    // Power-up blocking latch: live faults hold it, clear drops it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= 1'b0;
        else if (latch_en && (gen_live || trk_live || cb_live))
            blk_q <= 1'b1;
        else if (clr_evt)
            blk_q <= 1'b0;
        else if (latch_en && (irq_q || fsd_req || crowbar))
            blk_q <= 1'b1;
    end

    assign irq_n     = !irq_q;
    assign trk_irq_n = !trk_q;
    assign pwr_block = blk_q;
endmodule

// File: rtl/fr_checker.sv
// Checker: port-level temporal properties of the fault-response controller.
module fr_checker #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_done,
    input logic            irq_clr_n,
    input logic            trk_err,
    input logic            en_trk,
    input logic            irq_fsd_en,
    input logic            cb_level_mode,
    input logic [N_CH-1:0] oc,
    input logic [N_CH-1:0] en_oc_cb,
    input logic            irq_n,
    input logic            trk_irq_n,
    input logic            fsd_req,
    input logic            crowbar
);
    AST_TRK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trk_irq_n) |-> $past(trk_err && en_trk)); // R4
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> (!$past(irq_clr_n, 2) || !$past(rst_done))); // R2
    AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_done |=> irq_n); // R3
    AST_FSD_FROM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && irq_fsd_en) |-> fsd_req); // R5
    AST_CB_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_level_mode && |(oc & en_oc_cb)) |-> crowbar); // R8
endmodule

bind fault_resp_ctrl fr_checker #(.N_CH(N_CH)) i_fr_checker (
    .clk(clk), .rst_n(rst_n), .rst_done(rst_done), .irq_clr_n(irq_clr_n),
    .trk_err(trk_err), .en_trk(en_trk), .irq_fsd_en(irq_fsd_en),
    .cb_level_mode(cb_level_mode), .oc(oc), .en_oc_cb(en_oc_cb),
    .irq_n(irq_n), .trk_irq_n(trk_irq_n), .fsd_req(fsd_req), .crowbar(crowbar)
);

// File: tb/test_fault_resp_ctrl.sv
module test_fault_resp_ctrl;
    localparam int N = 4;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n, ms_tick, rst_done, trk_err, fsd_in, irq_clr_n;
    logic [N-1:0] uv, ov, uv1, uv2, oc, en_uv, en_ov, en_uv1, en_uv2, en_oc_irq, en_oc_cb;
    logic en_trk, irq_fsd_en, irq_cb_en, trk_fsd_en, trk_cb_en, fsd_in_cb_en, latch_en, cb_level_mode;
    logic [2:0] holdoff_sel;
    logic irq_n, trk_irq_n, fsd_req, crowbar, pwr_block;
    int checks = 0, errors = 0;

    always #4 clk = !clk;

    fault_resp_ctrl #(.N_CH(N), .PULSE_CYC(PW)) i_fault_resp_ctrl (.*);

    // Entry: [10:6] faults {oc,uv2,uv1,ov,uv}, [5:1] matching enables, [0] expect irq asserted
    localparam logic [10:0] VEC [8] = '{
        {5'b00001, 5'b00001, 1'b1},
        {5'b00010, 5'b00010, 1'b1},
        {5'b00100, 5'b00100, 1'b1},
        {5'b01000, 5'b01000, 1'b1},
        {5'b10000, 5'b10000, 1'b1},
        {5'b00001, 5'b11110, 1'b0},
        {5'b11110, 5'b00001, 1'b0},
        {5'b10100, 5'b00101, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        irq_clr_n = 1'b0; cyc(5); irq_clr_n = 1'b1; cyc(4);
    endtask

    task automatic set_ch(input int ch, input logic [4:0] f, input logic [4:0] e);
        {oc[ch], uv2[ch], uv1[ch], ov[ch], uv[ch]} = f;
        {en_oc_irq[ch], en_uv2[ch], en_uv1[ch], en_ov[ch], en_uv[ch]} = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        rst_n = 0; ms_tick = 1; rst_done = 0; trk_err = 0; fsd_in = 0; irq_clr_n = 1;
        {uv, ov, uv1, uv2, oc} = '0;
        {en_uv, en_ov, en_uv1, en_uv2, en_oc_irq, en_oc_cb} = '0;
        {en_trk, irq_fsd_en, irq_cb_en, trk_fsd_en, trk_cb_en, fsd_in_cb_en, latch_en, cb_level_mode} = '0;
        holdoff_sel = 3'd0;
        cyc(4);
        check("R10 irq_n", irq_n, 1'b1);
        check("R10 trk_irq_n", trk_irq_n, 1'b1);
        check("R10 fsd_req", fsd_req, 1'b0);
        check("R10 crowbar", crowbar, 1'b0);
        check("R10 pwr_block", pwr_block, 1'b0);
        rst_n = 1; rst_done = 1; cyc(2);

        // R1/R2: table of masking vectors, channels 0 and 2
        foreach (VEC[i]) begin
            set_ch((i % 2) * 2, VEC[i][10:6], VEC[i][5:1]);
            cyc(2);
            check("R1 mask", irq_n, !VEC[i][0]);
            set_ch((i % 2) * 2, 5'b0, 5'b0);
            cyc(2);
            check("R2 latched after fault gone", irq_n, !VEC[i][0]);
            pulse_clear();
            check("R2 cleared", irq_n, 1'b1);
        end

        // R2: clear while enabled fault still present keeps irq low
        set_ch(1, 5'b00010, 5'b00010); cyc(2);
        irq_clr_n = 0;
        for (int k = 0; k < 6; k++) begin cyc(1); check("R2 clear vs live fault", irq_n, 1'b0); end
        irq_clr_n = 1; set_ch(1, 5'b0, 5'b0); cyc(3);
        pulse_clear();
        check("R2 cleared after fault gone", irq_n, 1'b1);

        // R5: shutdown request from general interrupt
        irq_fsd_en = 1; uv[3] = 1; en_uv[3] = 1; cyc(2);
        check("R5 fsd from irq", fsd_req, 1'b1);
        uv[3] = 0; pulse_clear(); irq_fsd_en = 0;
        check("R5 fsd released", fsd_req, 1'b0);

        // R4: tracker only from trk_err & en_trk
        uv[0] = 1; en_uv[0] = 1; trk_err = 1; cyc(3);
        check("R4 trk ignores disabled err and general faults", trk_irq_n, 1'b1);
        uv[0] = 0; trk_err = 0; pulse_clear();
        en_trk = 1; trk_fsd_en = 1; trk_err = 1; cyc(2);
        check("R4 trk asserted", trk_irq_n, 1'b0);
        check("R5 fsd from trk", fsd_req, 1'b1);
        check("R4 general irq untouched", irq_n, 1'b1);
        trk_err = 0; cyc(2);
        check("R4 trk latched", trk_irq_n, 1'b0);
        pulse_clear(); en_trk = 0; trk_fsd_en = 0;
        check("R4 trk cleared", trk_irq_n, 1'b1);

        // R6/R7: oc to crowbar without irq; pulse width with mid-pulse retrigger
        en_oc_cb[1] = 1; oc[1] = 1; hi = 0;
        for (int k = 0; k < 20; k++) begin
            cyc(1);
            if (crowbar) hi++;
            if (k == 2) oc[1] = 0;
            if (k == 4) oc[1] = 1;
        end
        check("R7 pulse width no extension", hi == PW, 1'b1);
        check("R6 oc crowbar path leaves irq high", irq_n, 1'b1);
        oc[1] = 0; en_oc_cb[1] = 0; cyc(2);
        // R6: oc with irq enable only does not fire crowbar
        en_oc_irq[1] = 1; oc[1] = 1; hi = 0;
        for (int k = 0; k < 12; k++) begin cyc(1); if (crowbar) hi++; end
        check("R6 oc irq-only no crowbar", hi == 0, 1'b1);
        check("R6 oc irq-only raises irq", irq_n, 1'b0);
        oc[1] = 0; en_oc_irq[1] = 0; pulse_clear();
        // R6: general interrupt fires crowbar when enabled
        irq_cb_en = 1; uv2[2] = 1; en_uv2[2] = 1; cyc(3);
        check("R6 irq triggers crowbar", crowbar, 1'b1);
        uv2[2] = 0; en_uv2[2] = 0; irq_cb_en = 0; pulse_clear(); cyc(PW);

        // R8: level mode follows fsd_in trigger
        cb_level_mode = 1; fsd_in_cb_en = 1; fsd_in = 1; #1;
        check("R8 level high", crowbar, 1'b1);
        fsd_in = 0; #1;
        check("R8 level low", crowbar, 1'b0);
        cb_level_mode = 0; fsd_in_cb_en = 0; cyc(2);

        // R9: blocking latch
        uv[0] = 1; en_uv[0] = 1; cyc(3);
        check("R9 no block when disabled", pwr_block, 1'b0);
        uv[0] = 0; pulse_clear();
        latch_en = 1; uv[0] = 1; cyc(3); uv[0] = 0; cyc(3);
        check("R9 block held", pwr_block, 1'b1);
        pulse_clear();
        check("R9 block cleared", pwr_block, 1'b0);
        latch_en = 0; en_uv[0] = 0;

        // R3: hold-off lengths, code 1 and saturated code 6
        rst_done = 0; holdoff_sel = 3'd1; uv[2] = 1; en_uv[2] = 1; cyc(3);
        check("R3 held while in reset", irq_n, 1'b1);
        rst_done = 1; cyc(190);
        check("R3 before 200 ticks", irq_n, 1'b1);
        cyc(20);
        check("R3 after 200 ticks", irq_n, 1'b0);
        rst_done = 0; holdoff_sel = 3'd6; cyc(3); rst_done = 1; cyc(1580);
        check("R3 code 6 before 1600", irq_n, 1'b1);
        cyc(40);
        check("R3 code 6 after 1600", irq_n, 1'b0);
        uv[2] = 0; pulse_clear();
        check("R2 final clear", irq_n, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule